// File: doc/BRIEF.md
# EEPROM Line Write Filter

This block sits in front of a bit-banged two-wire EEPROM slave engine and turns CPU register accesses into line updates for it. A write, either a full 16-bit word or a single byte lane, yields a clock level and a data level. Each level is taken from a bit position that is set at run time. The block does not forward these levels at once. It holds them as a pending pair, and it releases the previously held pair to the engine only when enough cycles have passed since the last real change of the lines. A burst of closely spaced writes therefore collapses into its final value.

Reads first push the pending pair to the engine and then ask the engine for its output data bit. The request carries an "advance" flag when the pending clock is low and the lines have been quiet for long enough, so the engine can answer as if the next clock cycle had already begun. The block places the returned bit at a configurable position in the read word and narrows the word for byte reads. All interval tests use a free-running 32-bit cycle count that the chip supplies.

Top module: `eeprom_bus_filter`

## Requirements
- R1: After reset the pending clock and data levels are both 0, `eng_cmt`, `eng_rd_req`, `rd_valid` and `rd_data` are 0, and the block treats the last change as infinitely old. The first write therefore commits, and the first read carries the advance flag.
- R2: A write's clock level is bit `cfg_scl_pos` of the write word, and its data level is bit `cfg_sdi_pos` of the same word.
- R3: A write that arrives less than 16 cycles after the last recorded change produces no commit (`eng_cmt` stays 0 in the next cycle). It only replaces the pending pair.
- R4: Any other write produces, in the next cycle, `eng_cmt`=1 with `eng_scl`/`eng_sda` equal to the pending pair held before the write. The write's own pair then becomes pending.
- R5: The change timestamp is set to the current count only by a committing write whose new pair differs from the pending pair it replaces. Nothing else moves it.
- R6: A byte write (`wr_byte`=1) stores `wr_data[7:0]` into a two-lane buffer. `wr_addr0`=0 selects lane 0, which is bits 15:8 of the word, and `wr_addr0`=1 selects lane 1, which is bits 7:0. The combined word is then handled as a word write. A word write leaves the buffer unchanged.
- R7: A read produces, in the next cycle, `eng_cmt`=1 carrying the pending pair together with `eng_rd_req`=1.
- R8: `eng_rd_adv` is 1 with that request exactly when the pending clock is 0 and at least 24 cycles have passed since the last change.
- R9: One cycle after `eng_rd_req`, `rd_valid`=1 and `rd_data` holds `eng_rd_bit` at bit `cfg_sdo_pos`. This position is captured with the read. A byte read at an even address returns bits 15:8, and one at an odd address returns bits 7:0. Both are zero-extended.
- R10: The elapsed interval is the unsigned 32-bit difference of the count and the timestamp, so it stays correct when the count wraps.
- R11: A read changes neither the pending pair nor the timestamp.
- R12: When `wr_en` and `rd_en` are both high, the write is performed and the read is dropped: no `eng_rd_req` and no `rd_valid` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_cnt | input | 32 | Free-running cycle count |
| wr_en | input | 1 | Write strobe |
| wr_byte | input | 1 | 1: byte write, 0: word write |
| wr_addr0 | input | 1 | Address bit 0 for byte writes |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_byte | input | 1 | 1: byte read, 0: word read |
| rd_addr0 | input | 1 | Address bit 0 for byte reads |
| cfg_scl_pos | input | 4 | Clock level bit position in write word |
| cfg_sdi_pos | input | 4 | Data level bit position in write word |
| cfg_sdo_pos | input | 4 | Data bit position in read word |
| eng_cmt | output | 1 | Commit pulse to the engine |
| eng_scl | output | 1 | Committed clock level |
| eng_sda | output | 1 | Committed data level |
| eng_rd_req | output | 1 | Read query to the engine |
| eng_rd_adv | output | 1 | Query asks for the next-cycle view |
| eng_rd_bit | input | 1 | Engine data bit answering the query |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |

## Verification
On every cycle the assertions check the local consequences of each access. A short-gap write never commits. A first write always passes on the old pair. A read always flushes the pair and raises its query without touching the pending pair or the timestamp. A query is always followed by valid data. The timestamp moves only after a changing write, and a collision never produces a query. Only the bench's scenarios can show that the thresholds sit exactly at 15/16 and 23/24 cycles, including across a counter wrap. They also show that the byte lanes merge with their buffered partner and that the configured bit positions land where they should.

// File: rtl/eebf_pkg.sv
package eebf_pkg;

    parameter int STAMP_W = 32;

    typedef logic [STAMP_W-1:0] stamp_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    // True when no change was ever recorded or the wrap-safe gap reaches lim.
    function automatic logic gap_reached(input logic seen, input stamp_t now,
                                         input stamp_t last, input stamp_t lim);
        stamp_t gap;
        gap = now - last;
        return !seen || (gap >= lim);
    endfunction

endpackage

// File: rtl/eebf_lane_buf.sv
module eebf_lane_buf #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_go,
    input  logic          wr_byte,
    input  logic          wr_addr0,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] word_o
);
    localparam int LW = DW / 2;

    logic [LW-1:0] lane_q   [2];
    logic [LW-1:0] lane_now [2];

    for (genvar i = 0; i < 2; i++) begin : g_lane
        // lane 0 is the high half of the word
        logic hit;
        assign hit         = wr_byte && (wr_addr0 == 1'(i));
        assign lane_now[i] = hit ? wr_data[LW-1:0] : lane_q[i];

        always_ff @(posedge clk) begin
            if (rst)
                lane_q[i] <= '0;
            else if (wr_go && hit)
                lane_q[i] <= wr_data[LW-1:0];
        end
    end

    assign word_o = wr_byte ? {lane_now[0], lane_now[1]} : wr_data;

endmodule

// File: rtl/eebf_pending.sv
module eebf_pending
    import eebf_pkg::*;
#(
    parameter int DW     = 16,
    parameter int PW     = 4,
    parameter int WR_GAP = 16,
    parameter int RD_GAP = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op_i,
    input  stamp_t        now_i,
    input  logic [DW-1:0] word_i,
    input  logic [PW-1:0] scl_pos_i,
    input  logic [PW-1:0] sdi_pos_i,
    output logic          eng_cmt_o,
    output lines_t        eng_lines_o,
    output logic          eng_rd_req_o,
    output logic          eng_rd_adv_o
);
    localparam stamp_t WR_LIM = STAMP_W'(WR_GAP);
    localparam stamp_t RD_LIM = STAMP_W'(RD_GAP);

    lines_t pend_q;
    stamp_t last_q;
    logic   seen_q;
    lines_t new_lines;
    logic   wr_commit;
    logic   rd_adv;

    always_comb begin
        new_lines.scl = word_i[scl_pos_i];
        new_lines.sda = word_i[sdi_pos_i];
        wr_commit     = gap_reached(seen_q, now_i, last_q, WR_LIM);
        rd_adv        = !pend_q.scl && gap_reached(seen_q, now_i, last_q, RD_LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= '0;
            last_q       <= '0;
            seen_q       <= 1'b0;
            eng_cmt_o    <= 1'b0;
            eng_lines_o  <= '0;
            eng_rd_req_o <= 1'b0;
            eng_rd_adv_o <= 1'b0;
        end else begin
            eng_cmt_o    <= 1'b0;
            eng_rd_req_o <= 1'b0;
            eng_rd_adv_o <= 1'b0;
            case (op_i)
                OP_WRITE: begin
                    pend_q <= new_lines;
                    if (wr_commit) begin
                        eng_cmt_o   <= 1'b1;
                        eng_lines_o <= pend_q;
                        if (new_lines != pend_q) begin
                            last_q <= now_i;
                            seen_q <= 1'b1;
                        end
                    end
                end
                OP_READ: begin
                    eng_cmt_o    <= 1'b1;
                    eng_lines_o  <= pend_q;
                    eng_rd_req_o <= 1'b1;
                    eng_rd_adv_o <= rd_adv;
                end
                default: ;
            endcase
        end
    end

    a_r3_short_write_no_commit: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_WRITE && seen_q && ((now_i - last_q) < WR_LIM)) |=> !eng_cmt_o);

    a_r4_first_write_passes_old: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_WRITE && !seen_q) |=> (eng_cmt_o && eng_lines_o == $past(pend_q)));

    a_r5_stamp_moves_on_change: assert property (@(posedge clk) disable iff (rst)
        !$stable(last_q) |-> ($past(op_i) == OP_WRITE && $past(new_lines) != $past(pend_q)));

    a_r7_read_flushes: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_READ) |=> (eng_cmt_o && eng_rd_req_o && eng_lines_o == $past(pend_q)));

    a_r11_read_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_READ) |=> ($stable(pend_q) && $stable(last_q)));

    a_r8_adv_rides_request: assert property (@(posedge clk) disable iff (rst)
        eng_rd_adv_o |-> eng_rd_req_o);

endmodule

// File: rtl/eebf_read_path.sv
module eebf_read_path #(
    parameter int DW = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_go,
    input  logic          rd_byte,
    input  logic          rd_addr0,
    input  logic [PW-1:0] sdo_pos,
    input  logic          eng_rd_req_i,
    input  logic          eng_rd_bit_i,
    output logic          rd_valid_o,
    output logic [DW-1:0] rd_data_o
);
    localparam int LW = DW / 2;

    logic          byte_q;
    logic          addr_q;
    logic [PW-1:0] pos_q;
    logic [DW-1:0] word;
    logic [DW-1:0] shaped;

    always_comb begin
        word = DW'(eng_rd_bit_i) << pos_q;
        if (!byte_q)
            shaped = word;
        else if (addr_q)
            shaped = {{(DW-LW){1'b0}}, word[LW-1:0]};
        else
            shaped = word >> LW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q     <= 1'b0;
            addr_q     <= 1'b0;
            pos_q      <= '0;
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            if (rd_go) begin
                byte_q <= rd_byte;
                addr_q <= rd_addr0;
                pos_q  <= sdo_pos;
            end
            rd_valid_o <= eng_rd_req_i;
            if (eng_rd_req_i)
                rd_data_o <= shaped;
        end
    end

    a_r9_valid_after_request: assert property (@(posedge clk) disable iff (rst)
        eng_rd_req_i |=> rd_valid_o);

    a_r9_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && byte_q) |-> (rd_data_o[DW-1:LW] == '0));

endmodule

// File: rtl/eeprom_bus_filter.sv
module eeprom_bus_filter
    import eebf_pkg::*;
#(
    parameter int DW     = 16,
    parameter int WR_GAP = 16,
    parameter int RD_GAP = 24,
    localparam int PW    = $clog2(DW)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [STAMP_W-1:0]  cycle_cnt,
    input  logic                wr_en,
    input  logic                wr_byte,
    input  logic                wr_addr0,
    input  logic [DW-1:0]       wr_data,
    input  logic                rd_en,
    input  logic                rd_byte,
    input  logic                rd_addr0,
    input  logic [PW-1:0]       cfg_scl_pos,
    input  logic [PW-1:0]       cfg_sdi_pos,
    input  logic [PW-1:0]       cfg_sdo_pos,
    output logic                eng_cmt,
    output logic                eng_scl,
    output logic                eng_sda,
    output logic                eng_rd_req,
    output logic                eng_rd_adv,
    input  logic                eng_rd_bit,
    output logic                rd_valid,
    output logic [DW-1:0]       rd_data
);
    op_e           op;
    logic [DW-1:0] word;
    lines_t        lines;

    always_comb begin
        if (rst)        op = OP_IDLE;
        else if (wr_en) op = OP_WRITE;
        else if (rd_en) op = OP_READ;
        else            op = OP_IDLE;
    end

    eebf_lane_buf #(.DW(DW)) u_lanes (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (op == OP_WRITE),
        .wr_byte  (wr_byte),
        .wr_addr0 (wr_addr0),
        .wr_data  (wr_data),
        .word_o   (word)
    );

    eebf_pending #(.DW(DW), .PW(PW), .WR_GAP(WR_GAP), .RD_GAP(RD_GAP)) u_pend (
        .clk          (clk),
        .rst          (rst),
        .op_i         (op),
        .now_i        (cycle_cnt),
        .word_i       (word),
        .scl_pos_i    (cfg_scl_pos),
        .sdi_pos_i    (cfg_sdi_pos),
        .eng_cmt_o    (eng_cmt),
        .eng_lines_o  (lines),
        .eng_rd_req_o (eng_rd_req),
        .eng_rd_adv_o (eng_rd_adv)
    );

    assign eng_scl = lines.scl;
    assign eng_sda = lines.sda;

    eebf_read_path #(.DW(DW), .PW(PW)) u_rd (
        .clk          (clk),
        .rst          (rst),
        .rd_go        (op == OP_READ),
        .rd_byte      (rd_byte),
        .rd_addr0     (rd_addr0),
        .sdo_pos      (cfg_sdo_pos),
        .eng_rd_req_i (eng_rd_req),
        .eng_rd_bit_i (eng_rd_bit),
        .rd_valid_o   (rd_valid),
        .rd_data_o    (rd_data)
    );

    a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> !eng_rd_req);

endmodule

// File: tb/eeprom_bus_filter_bench.sv
`timescale 1ns/1ps
module eeprom_bus_filter_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cycle_cnt;
    logic        wr_en, wr_byte, wr_addr0, rd_en, rd_byte, rd_addr0;
    logic [15:0] wr_data;
    logic [3:0]  cfg_scl_pos, cfg_sdi_pos, cfg_sdo_pos;
    logic        eng_cmt, eng_scl, eng_sda, eng_rd_req, eng_rd_adv, eng_rd_bit;
    logic        rd_valid;
    logic [15:0] rd_data;

    always #2.5 clk = ~clk;

    eeprom_bus_filter u_eeprom_bus_filter (
        .clk(clk), .rst(rst), .cycle_cnt(cycle_cnt),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_addr0(wr_addr0), .wr_data(wr_data),
        .rd_en(rd_en), .rd_byte(rd_byte), .rd_addr0(rd_addr0),
        .cfg_scl_pos(cfg_scl_pos), .cfg_sdi_pos(cfg_sdi_pos), .cfg_sdo_pos(cfg_sdo_pos),
        .eng_cmt(eng_cmt), .eng_scl(eng_scl), .eng_sda(eng_sda),
        .eng_rd_req(eng_rd_req), .eng_rd_adv(eng_rd_adv), .eng_rd_bit(eng_rd_bit),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // reference state
    logic [31:0] cnt;
    logic [7:0]  m_lane0, m_lane1;
    logic        m_scl, m_sda, m_seen;
    logic [31:0] m_last;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic gap_ok(input logic [31:0] now, input int lim);
        logic [31:0] g;
        g = now - m_last;
        return !m_seen || (g >= 32'(lim));
    endfunction

    function automatic logic [15:0] read_shape(input logic b, input logic [3:0] pos,
                                               input logic byt, input logic a0);
        logic [15:0] w;
        w = 16'(b) << pos;
        if (!byt) return w;
        return a0 ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
    endfunction

    task automatic advance();
        @(negedge clk);
        cnt++;
        cycle_cnt = cnt;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) advance();
    endtask

    task automatic do_write(input logic byt, input logic a0, input logic [15:0] d,
                            input string tag);
        logic [15:0] w;
        logic ns, nd, commit, os, od;
        if (byt) begin
            if (a0) m_lane1 = d[7:0]; else m_lane0 = d[7:0];
            w = {m_lane0, m_lane1};
        end else
            w = d;
        ns = w[cfg_scl_pos];
        nd = w[cfg_sdi_pos];
        commit = gap_ok(cnt, 16);
        os = m_scl; od = m_sda;
        wr_en = 1'b1; wr_byte = byt; wr_addr0 = a0; wr_data = d;
        if (commit && {ns, nd} != {os, od}) begin m_last = cnt; m_seen = 1'b1; end
        m_scl = ns; m_sda = nd;
        advance();
        wr_en = 1'b0;
        chk(commit ? {tag, " R4 commit"} : {tag, " R3 hold"}, 32'(eng_cmt), 32'(commit));
        if (commit) begin
            chk({tag, " R4 scl"}, 32'(eng_scl), 32'(os));
            chk({tag, " R4 sda"}, 32'(eng_sda), 32'(od));
        end
    endtask

    task automatic do_read(input logic byt, input logic a0, input logic b, input string tag);
        logic adv;
        logic [3:0] pos;
        adv = !m_scl && gap_ok(cnt, 24);
        pos = cfg_sdo_pos;
        rd_en = 1'b1; rd_byte = byt; rd_addr0 = a0;
        advance();
        rd_en = 1'b0;
        chk({tag, " R7 cmt"}, 32'(eng_cmt), 32'd1);
        chk({tag, " R7 req"}, 32'(eng_rd_req), 32'd1);
        chk({tag, " R7 lines"}, {30'd0, eng_scl, eng_sda}, {30'd0, m_scl, m_sda});
        chk({tag, " R8 adv"}, 32'(eng_rd_adv), 32'(adv));
        eng_rd_bit = b;
        advance();
        eng_rd_bit = 1'b0;
        chk({tag, " R9 valid"}, 32'(rd_valid), 32'd1);
        chk({tag, " R9 data"}, 32'(rd_data), 32'(read_shape(b, pos, byt, a0)));
    endtask

    // wait until (cnt - last) equals k; requires cnt - last <= k
    task automatic idle_to_gap(input int k);
        while ((cnt - m_last) < 32'(k)) advance();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        cnt = 32'hFFFF_FFC0;
        cycle_cnt = cnt;
        rst = 1'b1;
        wr_en = 0; wr_byte = 0; wr_addr0 = 0; wr_data = 0;
        rd_en = 0; rd_byte = 0; rd_addr0 = 0; eng_rd_bit = 0;
        cfg_scl_pos = 4'd1; cfg_sdi_pos = 4'd0; cfg_sdo_pos = 4'd0;
        m_lane0 = 0; m_lane1 = 0; m_scl = 0; m_sda = 0; m_seen = 0; m_last = 0;
        idle(3);
        rst = 1'b0;
        advance();
        // R1 reset state
        chk("R1 cmt", 32'(eng_cmt), 0);
        chk("R1 req", 32'(eng_rd_req), 0);
        chk("R1 valid", 32'(rd_valid), 0);
        chk("R1 data", 32'(rd_data), 0);
        // R1 first read advances
        do_read(1'b0, 1'b0, 1'b1, "R1 first read");
        // R1 first write commits the reset pair
        do_write(1'b0, 1'b0, 16'h0003, "R1 first write");
        // R3 close write only replaces pending
        idle(3);
        do_write(1'b0, 1'b0, 16'h0001, "R3 close");
        // R3/R4 boundary 15 vs 16 (count wraps nearby: R10)
        idle_to_gap(15);
        do_write(1'b0, 1'b0, 16'h0000, "R3 gap15");
        idle_to_gap(16);
        do_write(1'b0, 1'b0, 16'h0002, "R10 R4 gap16");
        // R5: same-value committing write keeps the stamp
        idle(20);
        do_write(1'b0, 1'b0, 16'h0002, "R5 same");
        idle(2);
        do_write(1'b0, 1'b0, 16'h0002, "R5 again");
        // R8 boundary with clock low
        do_write(1'b0, 1'b0, 16'h0000, "R8 set low");
        idle_to_gap(23);
        do_read(1'b0, 1'b0, 1'b1, "R8 gap23");
        idle_to_gap(24);
        do_read(1'b0, 1'b0, 1'b1, "R8 gap24");
        // R11: read does not move the stamp; write right after still commits
        idle(20);
        do_read(1'b0, 1'b0, 1'b0, "R11 read");
        do_write(1'b0, 1'b0, 16'h0003, "R11 write");
        // R6 byte lanes with wide positions (R2)
        cfg_scl_pos = 4'd9; cfg_sdi_pos = 4'd2;
        idle(20);
        do_write(1'b1, 1'b0, 16'h0002, "R6 hi lane");
        idle(20);
        do_write(1'b1, 1'b1, 16'h0004, "R6 lo lane");
        idle(20);
        do_write(1'b0, 1'b0, 16'h0000, "R6 word");
        idle(20);
        do_write(1'b1, 1'b1, 16'h0000, "R6 buffer kept");
        idle(20);
        do_write(1'b0, 1'b0, 16'h0000, "R2 flush");
        // R9 byte reads
        cfg_sdo_pos = 4'd12;
        do_read(1'b1, 1'b0, 1'b1, "R9 even");
        do_read(1'b1, 1'b1, 1'b1, "R9 odd");
        cfg_sdo_pos = 4'd5;
        do_read(1'b1, 1'b1, 1'b1, "R9 odd low");
        do_read(1'b1, 1'b0, 1'b1, "R9 even low");
        // R12 collision
        idle(20);
        wr_en = 1'b1; rd_en = 1'b1; wr_byte = 1'b0; wr_data = 16'h0200;
        m_scl = 1'b1; m_sda = 1'b0;
        if (gap_ok(cnt, 16)) begin m_last = cnt; m_seen = 1'b1; end
        advance();
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R12 write done", 32'(eng_cmt), 1);
        chk("R12 no req", 32'(eng_rd_req), 0);
        advance();
        chk("R12 no valid", 32'(rd_valid), 0);
        // random phase
        for (int op = 0; op < 400; op++) begin
            if (op % 50 == 0) begin
                cfg_scl_pos = 4'($urandom_range(0, 15));
                cfg_sdi_pos = 4'($urandom_range(0, 15));
                cfg_sdo_pos = 4'($urandom_range(0, 15));
            end
            idle($urandom_range(0, 30));
            case ($urandom_range(0, 2))
                0: do_write(1'b0, 1'b0, 16'($urandom), "R2 rand word");
                1: do_write(1'b1, 1'($urandom), 16'($urandom), "R6 rand byte");
                default: do_read(1'($urandom), 1'($urandom), 1'($urandom), "R9 rand read");
            endcase
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule